// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt sources for a small CPU core: two active-low external pins, two timer overflow events and one serial port. It turns each into a request flag, masks the flags with a master enable and per-source enables, and splits the surviving requests into a high and a low priority level. From these it raises one vectored request toward the CPU. The external pins are sampled once per machine cycle. Each pin can be set to edge or level sensing.

When the CPU acknowledges the request, the block marks the winning level as in service. It also clears the winning flag if that flag is cleared by hardware. A return strobe ends the most urgent handler still running. A high-level request may interrupt a low-level handler. A low-level request never interrupts a high-level handler, and it waits while a low-level handler is running. Inside one level, a fixed scan order decides between sources.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `in_svc` is 00 and every bit of `flag_st` is 0 while the pins are high and the serial flags are low.
- R2: While `en_reg[7]` is 0, `irq_req` stays 0 whatever the other enable bits and flags are.
- R3: A source whose enable bit is 0 is never requested. The enable bit positions are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. `flag_st` uses the same positions.
- R4: Among pending requests of one level, the scan order is external 0, timer 0, external 1, timer 1, serial. Source k presents vector 0x0003 + 8*k, which gives 0003, 000B, 0013, 001B and 0023.
- R5: `pri_reg` uses the same bit positions as the enables, and a 1 places the source at the high level. A high-level request wins over any low-level request, whatever the scan order.
- R6: While the high level is in service (`in_svc[1]`), no request is raised. While only the low level is in service (`in_svc[0]`), only high-level requests are raised.
- R7: An accepted `vec_ack` while `irq_req` is 1 sets the in-service bit of the winning level and drops `irq_req` for the next cycle. A `reti` pulse clears `in_svc[1]` if it is set, and otherwise clears `in_svc[0]`.
- R8: In edge mode (`edge_mode[i]`=1), a pin sample of 1 followed by a sample of 0 sets the external flag. The flag stays set after the pin returns high, and it clears when its vector is acknowledged.
- R9: In level mode, the external flag is the inverse of the latest pin sample. Acknowledging its vector does not clear it.
- R10: A one-cycle `tmr_ovf[k]` pulse sets the timer flag. The flag clears when its vector is acknowledged.
- R11: The serial flag is the OR of `ser_rx` and `ser_tx`. Acknowledging the serial vector leaves it set.
- R12: A pin that is already low when edge mode is selected does not set the flag. A rising transition does not set it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_n | input | 2 | Active-low external interrupt pins |
| edge_mode | input | 2 | 1 selects edge sensing for each pin, 0 selects level sensing |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 timer 0, bit 1 timer 1) |
| ser_rx | input | 1 | Serial receive-done flag (cleared by software) |
| ser_tx | input | 1 | Serial transmit-done flag (cleared by software) |
| en_reg | input | 8 | Bit 7 master enable, bits 4..0 per-source enables |
| pri_reg | input | 8 | Bits 4..0: 1 places the source at the high level |
| vec_ack | input | 1 | CPU takes the presented vector |
| reti | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | Vectored request to the CPU |
| irq_vec | output | 16 | Vector address of the current winner |
| flag_st | output | 5 | Request flag of each source |
| in_svc | output | 2 | In-service bits: bit 1 high level, bit 0 low level |

## Verification
The bench builds the block with a machine cycle of 4 clocks instead of the default 12, and keeps the default vector base and stride. The short machine cycle means pin sampling, edge detection and level following can each be shown within a few dozen clocks. Preemption sequences that nest both levels and then unwind them with two returns also fit in a short directed run. The default vector parameters let the bench check all five vector addresses directly.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int SRC_N = 5;
    localparam int IDX_W = $clog2(SRC_N);

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_e;

    // lowest set bit wins: bit order equals scan order
    function automatic logic [IDX_W-1:0] first_set(input logic [SRC_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/irq_ext_sampler.sv
module irq_ext_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic samp;
        logic eflag;
    } smp_t;

    smp_t st_d, st_q;
    logic fall;

    always_comb begin
        st_d = st_q;
        fall = tick_i & st_q.samp & ~pin_n_i;
        if (tick_i) st_d.samp = pin_n_i;
        if (edge_mode_i) st_d.eflag = (st_q.eflag & ~clr_i) | fall;
        else             st_d.eflag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.samp  <= 1'b1;
            st_q.eflag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = edge_mode_i ? st_q.eflag : ~st_q.samp;

    p_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && flag_o && !clr_i) |=> (!edge_mode_i || flag_o));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [SRC_N-1:0] pend_i,
    input  logic [SRC_N-1:0] hi_mask_i,
    input  logic [1:0]       ins_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             hi_o,
    output logic [SRC_N-1:0] grant_o
);
    logic [SRC_N-1:0] lvl_pend [2];
    logic [IDX_W-1:0] lvl_idx  [2];
    logic [1:0]       lvl_any;
    logic [1:0]       lvl_ok;

    assign lvl_pend[0] = pend_i & ~hi_mask_i;
    assign lvl_pend[1] = pend_i &  hi_mask_i;
    assign lvl_ok[1]   = ~ins_i[1];
    assign lvl_ok[0]   = ~ins_i[1] & ~ins_i[0];

    for (genvar g = 0; g < 2; g++) begin : g_lvl
        assign lvl_any[g] = |lvl_pend[g];
        assign lvl_idx[g] = first_set(lvl_pend[g]);
    end

    always_comb begin
        valid_o = 1'b0;
        hi_o    = 1'b0;
        idx_o   = '0;
        if (lvl_ok[1] && lvl_any[1]) begin
            valid_o = 1'b1;
            hi_o    = 1'b1;
            idx_o   = lvl_idx[1];
        end else if (lvl_ok[0] && lvl_any[0]) begin
            valid_o = 1'b1;
            idx_o   = lvl_idx[0];
        end
        grant_o = valid_o ? (SRC_N'(1) << idx_o) : '0;
    end

    always_comb begin
        p_grant_pending_r4: assert (((grant_o & ~pend_i) == '0) && $onehot0(grant_o));
        if (lvl_any[1] && !ins_i[1])
            p_high_first_r5: assert (valid_o && hi_o);
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int          SAMPLE_DIV = 12,
    parameter int          VEC_W      = 16,
    parameter logic [15:0] VEC_BASE   = 16'h0003,
    parameter int          VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ext_n,
    input  logic [1:0]       edge_mode,
    input  logic [1:0]       tmr_ovf,
    input  logic             ser_rx,
    input  logic             ser_tx,
    input  logic [7:0]       en_reg,
    input  logic [7:0]       pri_reg,
    input  logic             vec_ack,
    input  logic             reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [SRC_N-1:0] flag_st,
    output logic [1:0]       in_svc
);
    localparam int EA_BIT = 7;

    typedef struct packed {
        logic [1:0]       tmr_flag;
        logic [1:0]       ins;
        logic             req;
        logic [IDX_W-1:0] win;
        logic             win_hi;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             tick;
    logic [1:0]       ext_flag;
    logic [1:0]       ext_clr;
    logic [1:0]       tmr_clr;
    logic             ack_take;
    logic [SRC_N-1:0] pend;
    logic             arb_valid;
    logic [IDX_W-1:0] arb_idx;
    logic             arb_hi;
    logic [SRC_N-1:0] arb_grant;
    logic             unused_bits;

    assign unused_bits = ^{en_reg[6:5], pri_reg[7:5], arb_grant};

    irq_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar g = 0; g < 2; g++) begin : g_ext
        irq_ext_sampler u_smp (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick),
            .pin_n_i     (ext_n[g]),
            .edge_mode_i (edge_mode[g]),
            .clr_i       (ext_clr[g]),
            .flag_o      (ext_flag[g])
        );
    end

    assign ack_take   = vec_ack & st_q.req;
    assign ext_clr[0] = ack_take & (st_q.win == SRC_EXT0);
    assign ext_clr[1] = ack_take & (st_q.win == SRC_EXT1);
    assign tmr_clr[0] = ack_take & (st_q.win == SRC_TMR0);
    assign tmr_clr[1] = ack_take & (st_q.win == SRC_TMR1);

    assign flag_st = {ser_rx | ser_tx, st_q.tmr_flag[1], ext_flag[1],
                      st_q.tmr_flag[0], ext_flag[0]};
    assign pend    = flag_st & en_reg[SRC_N-1:0] & {SRC_N{en_reg[EA_BIT]}};

    irq_arbiter u_arb (
        .pend_i    (pend),
        .hi_mask_i (pri_reg[SRC_N-1:0]),
        .ins_i     (st_q.ins),
        .valid_o   (arb_valid),
        .idx_o     (arb_idx),
        .hi_o      (arb_hi),
        .grant_o   (arb_grant)
    );

    always_comb begin
        st_d = st_q;
        st_d.tmr_flag = (st_q.tmr_flag & ~tmr_clr) | tmr_ovf;
        if (reti) begin
            if (st_q.ins[1]) st_d.ins[1] = 1'b0;
            else             st_d.ins[0] = 1'b0;
        end
        if (ack_take) begin
            if (st_q.win_hi) st_d.ins[1] = 1'b1;
            else             st_d.ins[0] = 1'b1;
        end
        st_d.req    = arb_valid & ~ack_take;
        st_d.win    = arb_idx;
        st_d.win_hi = arb_hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req = st_q.req;
    assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(st_q.win) * VEC_W'(VEC_STRIDE);
    assign in_svc  = st_q.ins;

    p_ea_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_reg[EA_BIT] |=> !irq_req);
    p_hi_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc[1] |=> !irq_req);
    p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && irq_req) |=> !irq_req);
    p_reti_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_svc[1]) |=> !in_svc[1]);
    p_tmr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && irq_req && irq_vec == VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE)
         && !tmr_ovf[0]) |=> !flag_st[1]);
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  edge_mode = 2'b00;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_rx = 1'b0;
    logic        ser_tx = 1'b0;
    logic [7:0]  en_reg = 8'h00;
    logic [7:0]  pri_reg = 8'h00;
    logic        vec_ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [4:0]  flag_st;
    logic [1:0]  in_svc;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl #(.SAMPLE_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .edge_mode(edge_mode),
        .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx),
        .en_reg(en_reg), .pri_reg(pri_reg), .vec_ack(vec_ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .flag_st(flag_st), .in_svc(in_svc)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_mc(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic pulse_ovf(input int k);
        tmr_ovf[k] = 1'b1;
        @(negedge clk);
        tmr_ovf[k] = 1'b0;
    endtask

    task automatic do_ack();
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req", 16'(irq_req), 16'h0);
        chk("R1 in_svc", 16'(in_svc), 16'h0);
        chk("R1 flags", 16'(flag_st), 16'h0);
    endtask

    task automatic t_master_enable();
        pulse_ovf(0);
        en_reg = 8'h1F;
        settle();
        chk("R10 timer0 flag set", 16'(flag_st[1]), 16'h1);
        chk("R2 master enable off blocks", 16'(irq_req), 16'h0);
        en_reg = 8'h9F;
        settle();
        chk("R2 request after enable", 16'(irq_req), 16'h1);
        chk("R4 timer0 vector", irq_vec, 16'h000B);
        do_ack();
        chk("R7 ack drops request", 16'(irq_req), 16'h0);
        chk("R10 timer0 flag cleared", 16'(flag_st[1]), 16'h0);
        chk("R7 low in service", 16'(in_svc), 16'h1);
        do_reti();
        settle();
        chk("R7 reti clears low", 16'(in_svc), 16'h0);
        chk("R10 nothing left", 16'(irq_req), 16'h0);
    endtask

    task automatic t_scan_order();
        en_reg = 8'h9F;
        pri_reg = 8'h00;
        pulse_ovf(1);
        pulse_ovf(0);
        ser_rx = 1'b1;
        settle();
        chk("R4 first is timer0", irq_vec, 16'h000B);
        do_ack(); do_reti(); settle();
        chk("R4 second is timer1", irq_vec, 16'h001B);
        do_ack(); do_reti(); settle();
        chk("R4 third is serial", irq_vec, 16'h0023);
        do_ack();
        chk("R11 serial flag kept", 16'(flag_st[4]), 16'h1);
        ser_rx = 1'b0;
        ser_tx = 1'b1;
        settle();
        chk("R11 tx alone sets flag", 16'(flag_st[4]), 16'h1);
        chk("R6 low blocked by low", 16'(irq_req), 16'h0);
        ser_tx = 1'b0;
        do_reti();
        settle();
        chk("R11 flag follows inputs", 16'(flag_st[4]), 16'h0);
        chk("R11 idle", 16'(irq_req), 16'h0);
    endtask

    task automatic t_source_enable();
        en_reg = 8'h84;
        pulse_ovf(0);
        pulse_ovf(1);
        settle();
        chk("R3 flags present", 16'(flag_st), 16'h000A);
        chk("R3 disabled not requested", 16'(irq_req), 16'h0);
        en_reg = 8'h8C;
        settle();
        chk("R3 timer1 enabled", irq_vec, 16'h001B);
        do_ack(); do_reti();
        en_reg = 8'h8E;
        settle();
        chk("R3 timer0 enabled", irq_vec, 16'h000B);
        do_ack(); do_reti(); settle();
        chk("R3 idle", 16'(irq_req), 16'h0);
        en_reg = 8'h84;
        edge_mode = 2'b00;
        ext_n[1] = 1'b0;
        wait_mc(3);
        chk("R9 ext1 level req", 16'(irq_req), 16'h1);
        chk("R4 ext1 vector", irq_vec, 16'h0013);
        do_ack();
        chk("R9 level flag not cleared", 16'(flag_st[2]), 16'h1);
        ext_n[1] = 1'b1;
        wait_mc(3);
        chk("R9 level flag follows pin", 16'(flag_st[2]), 16'h0);
        do_reti();
        settle();
    endtask

    task automatic t_priority();
        en_reg = 8'h9F;
        pri_reg = 8'h10;
        pulse_ovf(0);
        ser_rx = 1'b1;
        settle();
        chk("R5 high serial wins", irq_vec, 16'h0023);
        do_ack();
        chk("R7 high in service", 16'(in_svc), 16'h2);
        settle();
        chk("R6 low blocked by high", 16'(irq_req), 16'h0);
        ser_rx = 1'b0;
        do_reti();
        settle();
        chk("R7 reti clears high", 16'(in_svc), 16'h0);
        chk("R6 low after return", irq_vec, 16'h000B);
        do_ack();
        pri_reg = 8'h18;
        pulse_ovf(1);
        settle();
        chk("R6 high preempts low", 16'(irq_req), 16'h1);
        chk("R6 preempt vector", irq_vec, 16'h001B);
        do_ack();
        chk("R7 both levels", 16'(in_svc), 16'h3);
        do_reti();
        chk("R7 reti clears highest", 16'(in_svc), 16'h1);
        do_reti();
        chk("R7 second reti", 16'(in_svc), 16'h0);
        pri_reg = 8'h00;
        settle();
    endtask

    task automatic t_edge();
        en_reg = 8'h81;
        edge_mode = 2'b01;
        ext_n[0] = 1'b0;
        wait_mc(3);
        chk("R8 edge flag set", 16'(flag_st[0]), 16'h1);
        chk("R8 ext0 vector", irq_vec, 16'h0003);
        ext_n[0] = 1'b1;
        wait_mc(3);
        chk("R8 flag held after release", 16'(flag_st[0]), 16'h1);
        do_ack();
        chk("R8 flag cleared on ack", 16'(flag_st[0]), 16'h0);
        do_reti();
        settle();
        chk("R8 idle", 16'(irq_req), 16'h0);
        edge_mode = 2'b00;
        ext_n[0] = 1'b0;
        wait_mc(3);
        chk("R9 level low sets flag", 16'(flag_st[0]), 16'h1);
        edge_mode = 2'b01;
        wait_mc(3);
        chk("R12 held low gives no edge", 16'(flag_st[0]), 16'h0);
        chk("R12 no request", 16'(irq_req), 16'h0);
        ext_n[0] = 1'b1;
        wait_mc(3);
        chk("R12 rising gives no edge", 16'(flag_st[0]), 16'h0);
        edge_mode = 2'b00;
        settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master_enable();
        t_scan_order();
        t_source_enable();
        t_priority();
        t_edge();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule